// File: doc/BRIEF.md
# FFT Working-Memory Address Generator

This block produces the word address that an FFT engine presents to its working memory. It holds two address counters. The first one only steps upward. The second steps up or down. An active-low select input decides which counter drives the address bus. Each counter can be loaded in parallel, which lets a sequencer place it at the start of a pass.

Two controls change the raw counter value on its way to the output. A page-mode input replaces the most significant address bit with a page bit. That bit comes from a small page register. The register chooses between the window page and the coefficient page, using the access direction and an active-low window-page request. Because coefficients are read-only, a write always selects the window page. A pass-through control can also hold address bit 0 at zero.

An optional post-increment advances whichever counter is selected on the clock edge that ends an access strobe. The address therefore stays constant for the whole strobe cycle, and the next word is ready for the following access.

Top module: `fft_addr_gen`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears both counters to 0 and sets the page bit to the coefficient page (0).
- R2: When `sel_a_n` is low, the address comes from counter A. When it is high, the address comes from counter B.
- R3: When `inc_a_n` is low, counter A advances by 1 at each rising edge, and it wraps from 4095 to 0.
- R4: When `inc_b_n` is low, counter B advances by 1. When `dec_b_n` is low, it goes back by 1. It wraps in both directions (4095 to 0, and 0 to 4095).
- R5: When an increment and `dec_b_n` are both active on counter B in the same cycle, counter B holds its value.
- R6: When `load_a` or `load_b` is high, the matching counter takes `load_val` at the next edge. A load overrides any increment, decrement or post-increment in that cycle.
- R7: The page bit is registered. At each edge it takes 1 (window page) if `wr` is high or `win_pg_n` is low, and 0 (coefficient page) otherwise. A write therefore never selects the coefficient page.
- R8: When `pg_mode` is high, address bit 11 equals the page bit. When it is low, bit 11 is bit 11 of the selected counter.
- R9: When `pass_b0` is low, address bit 0 is 0. When it is high, bit 0 is the bit 0 of the selected source.
- R10: When `acc_stb` is high and `post_inc_n` is low, the selected counter advances by 1 at the edge that ends the strobe cycle. The address is unchanged during that cycle, and the other counter is not touched. When `post_inc_n` is high, the strobe does not advance either counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_a | input | 1 | Parallel load of counter A |
| load_b | input | 1 | Parallel load of counter B |
| load_val | input | 12 | Value for a parallel load |
| inc_a_n | input | 1 | Increment counter A, active low |
| inc_b_n | input | 1 | Increment counter B, active low |
| dec_b_n | input | 1 | Decrement counter B, active low |
| sel_a_n | input | 1 | Low: counter A drives the address; high: counter B |
| wr | input | 1 | Access direction, high for a write |
| win_pg_n | input | 1 | Window page request, active low |
| pg_mode | input | 1 | Use the page bit as address bit 11 |
| pass_b0 | input | 1 | Pass address bit 0 when high; hold it at 0 when low |
| post_inc_n | input | 1 | Post-increment enable, active low |
| acc_stb | input | 1 | Access strobe |
| addr | output | 12 | Memory word address |

## Verification
The bench runs each counter through its full 4096-value range and checks the wrap at both ends. A counter sized or carried wrongly shows up as a missing or extra wrap. Counter B is checked with both of its step controls active together, where a design that favours one direction would drift instead of holding. The bench applies all four combinations of `wr` and `win_pg_n` with `pg_mode` high, so a page decode that let a write reach the coefficient page is caught on address bit 11. The bench also checks that the address is unchanged during a post-incremented strobe, and that the counter which is not selected stays put. A post-increment applied on the wrong edge, or to the wrong counter, fails at once.

// File: rtl/fft_addr_pkg.sv
package fft_addr_pkg;
   typedef enum logic {
      PAGE_COEF = 1'b0,
      PAGE_WIN  = 1'b1
   } page_e;

   // write always forces window page: coefficient store is read-only
   function automatic page_e pick_page(input logic wr, input logic win_req_n);
      return (wr || !win_req_n) ? PAGE_WIN : PAGE_COEF;
   endfunction
endpackage

// File: rtl/fft_addr_counter.sv
module fft_addr_counter #(
   parameter int W       = 12,
   parameter bit HAS_DEC = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         up,
   input  logic         down,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   generate
      if (HAS_DEC) begin : g_updown
         always_comb begin
            cnt_d = cnt_q;
            if (load)              cnt_d = load_val;
            else if (up && !down)  cnt_d = cnt_q + ONE;
            else if (down && !up)  cnt_d = cnt_q - ONE;
         end
      end else begin : g_up_only
         logic unused_down;
         assign unused_down = down;
         always_comb begin
            cnt_d = cnt_q;
            if (load)    cnt_d = load_val;
            else if (up) cnt_d = cnt_q + ONE;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count = cnt_q;
endmodule

// File: rtl/fft_addr_page.sv
module fft_addr_page
   import fft_addr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic win_pg_n,
   output logic page_win
);
   page_e pg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pg_q <= PAGE_COEF;
      else        pg_q <= pick_page(wr, win_pg_n);
   end

   assign page_win = (pg_q == PAGE_WIN);
endmodule

// File: rtl/fft_addr_mux.sv
module fft_addr_mux #(
   parameter int W = 12
) (
   input  logic [W-1:0] cnt_a,
   input  logic [W-1:0] cnt_b,
   input  logic         sel_a_n,
   input  logic         pg_mode,
   input  logic         page_win,
   input  logic         pass_b0,
   output logic [W-1:0] addr
);
   localparam int TOP = W - 1;

   logic [W-1:0] raw;

   always_comb begin
      raw = sel_a_n ? cnt_b : cnt_a;
      if (pg_mode) raw[TOP] = page_win;
      raw[0] = raw[0] & pass_b0;
   end

   assign addr = raw;
endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_a,
   input  logic              load_b,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc_a_n,
   input  logic              inc_b_n,
   input  logic              dec_b_n,
   input  logic              sel_a_n,
   input  logic              wr,
   input  logic              win_pg_n,
   input  logic              pg_mode,
   input  logic              pass_b0,
   input  logic              post_inc_n,
   input  logic              acc_stb,
   output logic [ADDR_W-1:0] addr
);
   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("fft_addr_gen: ADDR_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] cnt_a;
   logic [ADDR_W-1:0] cnt_b;
   logic              page_win;
   logic              post_step;
   logic              up_a;
   logic              up_b;
   logic              dn_b;

   // post-increment lands on the edge closing the strobe cycle
   assign post_step = acc_stb & ~post_inc_n;
   assign up_a      = ~inc_a_n | (post_step & ~sel_a_n);
   assign up_b      = ~inc_b_n | (post_step &  sel_a_n);
   assign dn_b      = ~dec_b_n;

   fft_addr_counter #(.W(ADDR_W), .HAS_DEC(1'b0)) u_cnt_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_a),
      .load_val (load_val),
      .up       (up_a),
      .down     (1'b0),
      .count    (cnt_a)
   );

   fft_addr_counter #(.W(ADDR_W), .HAS_DEC(1'b1)) u_cnt_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_b),
      .load_val (load_val),
      .up       (up_b),
      .down     (dn_b),
      .count    (cnt_b)
   );

   fft_addr_page u_page (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr),
      .win_pg_n (win_pg_n),
      .page_win (page_win)
   );

   fft_addr_mux #(.W(ADDR_W)) u_mux (
      .cnt_a    (cnt_a),
      .cnt_b    (cnt_b),
      .sel_a_n  (sel_a_n),
      .pg_mode  (pg_mode),
      .page_win (page_win),
      .pass_b0  (pass_b0),
      .addr     (addr)
   );
endmodule

module fft_addr_gen_chk #(
   parameter int W = 12
) (
   input logic         clk,
   input logic         rst_n,
   input logic         load_a,
   input logic         load_b,
   input logic         inc_a_n,
   input logic         inc_b_n,
   input logic         dec_b_n,
   input logic         sel_a_n,
   input logic         wr,
   input logic         pg_mode,
   input logic         pass_b0,
   input logic         post_inc_n,
   input logic         acc_stb,
   input logic [W-1:0] cnt_a,
   input logic [W-1:0] cnt_b,
   input logic         page_win,
   input logic [W-1:0] addr
);
   assert_a_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_a_n && !pg_mode && pass_b0) |-> (addr == cnt_a));

   assert_a_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_a && !inc_a_n) |=> (cnt_a == $past(cnt_a) + W'(1)));

   assert_b_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_b && !inc_b_n && !dec_b_n) |=> $stable(cnt_b));

   assert_write_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> page_win);

   assert_bit0_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_b0 |-> (addr[0] == 1'b0));

   assert_other_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && !post_inc_n && !sel_a_n && !load_b && inc_b_n && dec_b_n)
      |=> $stable(cnt_b));
endmodule

bind fft_addr_gen fft_addr_gen_chk #(.W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_a     (load_a),
   .load_b     (load_b),
   .inc_a_n    (inc_a_n),
   .inc_b_n    (inc_b_n),
   .dec_b_n    (dec_b_n),
   .sel_a_n    (sel_a_n),
   .wr         (wr),
   .pg_mode    (pg_mode),
   .pass_b0    (pass_b0),
   .post_inc_n (post_inc_n),
   .acc_stb    (acc_stb),
   .cnt_a      (cnt_a),
   .cnt_b      (cnt_b),
   .page_win   (page_win),
   .addr       (addr)
);

// File: tb/fft_addr_gen_bench.sv
module fft_addr_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        load_a, load_b;
   logic [11:0] load_val;
   logic        inc_a_n, inc_b_n, dec_b_n;
   logic        sel_a_n, wr, win_pg_n, pg_mode, pass_b0;
   logic        post_inc_n, acc_stb;
   logic [11:0] addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [11:0] ma, mb;
   logic        mp;

   always #5 clk = ~clk;

   fft_addr_gen u_fft_addr_gen (
      .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b),
      .load_val(load_val), .inc_a_n(inc_a_n), .inc_b_n(inc_b_n),
      .dec_b_n(dec_b_n), .sel_a_n(sel_a_n), .wr(wr), .win_pg_n(win_pg_n),
      .pg_mode(pg_mode), .pass_b0(pass_b0), .post_inc_n(post_inc_n),
      .acc_stb(acc_stb), .addr(addr)
   );

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] exp_addr();
      logic [11:0] m;
      m = sel_a_n ? mb : ma;
      if (pg_mode) m[11] = mp;
      m[0] = m[0] & pass_b0;
      return m;
   endfunction

   // advance one clock; model derived from the requirements
   task automatic tick();
      logic [11:0] na, nb;
      logic        np, up_a, up_b, dn_b;
      na = ma; nb = mb; np = mp;
      if (!rst_n) begin
         na = '0; nb = '0; np = 1'b0;
      end else begin
         up_a = !inc_a_n || (acc_stb && !post_inc_n && !sel_a_n);
         up_b = !inc_b_n || (acc_stb && !post_inc_n &&  sel_a_n);
         dn_b = !dec_b_n;
         if (load_a)    na = load_val;
         else if (up_a) na = ma + 12'd1;
         if (load_b)             nb = load_val;
         else if (up_b && !dn_b) nb = mb + 12'd1;
         else if (dn_b && !up_b) nb = mb - 12'd1;
         np = wr || !win_pg_n;
      end
      @(posedge clk);
      #1;
      ma = na; mb = nb; mp = np;
   endtask

   task automatic idle();
      load_a = 0; load_b = 0; load_val = '0;
      inc_a_n = 1; inc_b_n = 1; dec_b_n = 1;
      wr = 0; win_pg_n = 1; post_inc_n = 1; acc_stb = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_500_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      ma = 12'hABC; mb = 12'h123; mp = 1'b1;
      idle();
      sel_a_n = 0; pg_mode = 0; pass_b0 = 1;
      rst_n = 0;
      tick(); tick();
      rst_n = 1;
      // R1 reset state
      check("R1 counter A after reset", addr, 12'd0);
      sel_a_n = 1; #1;
      check("R1 counter B after reset", addr, 12'd0);
      pg_mode = 1; #1;
      check("R1 page bit after reset", {11'd0, addr[11]}, 12'd0);
      pg_mode = 0; sel_a_n = 0;

      // R3 full sweep of counter A with wrap
      inc_a_n = 0;
      for (int i = 0; i < 4100; i++) begin
         tick();
         check("R3 counter A sweep", addr, exp_addr());
      end
      inc_a_n = 1;

      // R4 counter B up sweep, then down across zero
      sel_a_n = 1; inc_b_n = 0;
      for (int i = 0; i < 4100; i++) begin
         tick();
         check("R4 counter B up", addr, exp_addr());
      end
      inc_b_n = 1; dec_b_n = 0;
      for (int i = 0; i < 10; i++) begin
         tick();
         check("R4 counter B down wrap", addr, exp_addr());
      end
      dec_b_n = 1;
      check("R4 counter B below zero", addr, 12'd4090);

      // R5 both directions hold
      inc_b_n = 0; dec_b_n = 0;
      for (int i = 0; i < 5; i++) begin
         tick();
         check("R5 counter B hold", addr, 12'd4090);
      end
      inc_b_n = 1; dec_b_n = 1;

      // R6 load wins over steps
      load_b = 1; load_val = 12'd4095; inc_b_n = 0; tick();
      load_b = 0; inc_b_n = 1;
      check("R6 load B", addr, 12'd4095);
      sel_a_n = 0; load_a = 1; load_val = 12'h5A5; inc_a_n = 0;
      acc_stb = 1; post_inc_n = 0; tick();
      load_a = 0; inc_a_n = 1; acc_stb = 0; post_inc_n = 1;
      check("R6 load A", addr, 12'h5A5);

      // R2 selection between counters
      sel_a_n = 0; #1; check("R2 select A", addr, 12'h5A5);
      sel_a_n = 1; #1; check("R2 select B", addr, 12'd4095);

      // R9 bit 0 gate on odd values
      pass_b0 = 0; #1; check("R9 gate B", addr, 12'd4094);
      sel_a_n = 0; #1; check("R9 gate A", addr, 12'h5A4);
      pass_b0 = 1; #1; check("R9 pass A", addr, 12'h5A5);

      // R7/R8 page decode over all direction/request combos
      for (int c = 0; c < 4; c++) begin
         wr = c[0]; win_pg_n = c[1];
         tick();
         pg_mode = 1; #1;
         check("R7 R8 page bit", addr, exp_addr());
         check("R7 page value", {11'd0, addr[11]}, {11'd0, (c[0] | ~c[1])});
         pg_mode = 0; #1;
         check("R8 counter bit 11", addr, 12'h5A5);
      end
      wr = 0; win_pg_n = 1;

      // R10 post-increment on selected counter only
      sel_a_n = 0; acc_stb = 1; post_inc_n = 0; #1;
      check("R10 stable during strobe", addr, 12'h5A5);
      tick();
      acc_stb = 0; post_inc_n = 1;
      check("R10 A advanced", addr, 12'h5A6);
      sel_a_n = 1; #1;
      check("R10 B untouched", addr, 12'd4095);
      acc_stb = 1; post_inc_n = 0; tick();
      acc_stb = 0; post_inc_n = 1;
      check("R10 B advanced wrap", addr, 12'd0);
      sel_a_n = 0; #1;
      check("R10 A untouched", addr, 12'h5A6);
      acc_stb = 1; post_inc_n = 1; tick();
      acc_stb = 0;
      check("R10 disabled no step", addr, 12'h5A6);

      // R1 reset again mid-run
      rst_n = 0; tick(); rst_n = 1;
      check("R1 reset clears A", addr, 12'd0);

      finish_run();
   end
endmodule